// File: doc/BRIEF.md
# Performance Level Scaling Controller

This block converts a software performance request, given as a percentage of full speed, into one of a small set of operating points. It then steers the clock-generation side and the voltage-control side toward that point. Software programs the request and a table of operating points through a zero-wait APB register interface. Each table entry holds a percentage threshold, a frequency code and a voltage code. The block drives a target index and its code to each side, and it watches the level each side reports back. These reports are thermometer-coded and come from unrelated clock domains.

Transitions are sequenced so that voltage always leads on the way up and trails on the way down. A hardware input can demand full performance at any time. A work meter counts active cycles over a programmable window, so software can judge whether the chosen point keeps up with its deadlines.

Top module: `perf_scale_ctrl`

## Requirements
- R1: After reset the status word reads 0, the request register reads 0, both target indices are 0, and both code outputs carry the reset code of level 0, which is 0. The reset codes of level i are i for both frequency and voltage, and its reset threshold is (i+1)*100/levels, giving 25, 50, 75 and 100 for four levels.
- R2: A request written above 100 to the request register (offset 0x00, bits 6:0) is stored and read back as 100.
- R3: The target is the lowest level whose threshold is greater than or equal to the stored request. If no threshold qualifies, the target is the highest level. Level i is configured at offset 0x10+4*i, with the threshold in bits 6:0, the frequency code in bits 15:8 and the voltage code in bits 23:16.
- R4: On a rise, the voltage-side index moves to the new target first. The clock-side index stays unchanged until the voltage side's confirmed level equals the target.
- R5: On a fall, the clock-side index moves first. The voltage-side index stays unchanged until the clock side's confirmed level equals the target.
- R6: A reported thermometer value changes a side's confirmed level only after two consecutive synchronized samples agree and the value is a legal pattern, meaning ones packed from bit 0 upward. The confirmed level is the number of ones, and a change at the input appears there no earlier than the fourth rising clock edge. A one-cycle glitch, or an illegal pattern such as 101, leaves the confirmed level unchanged.
- R7: The status word (offset 0x04) holds the target index in bits 7:0, the clock side's confirmed level in bits 15:8, the voltage side's confirmed level in bits 23:16, and the busy flag in bit 31. Busy is 1 while a transition is in progress.
- R8: A request written while busy does not disturb the transition in progress. Only the last such request is applied once it completes. When idle, both target indices are equal.
- R9: While the hardware maximum request input is high, the target is the highest level whatever the software request is. When the input drops, the target returns to the mapping of the stored request.
- R10: The work register (offset 0x0C) holds the number of cycles with the work input high during the last completed window. The window length in cycles is set at offset 0x08 (reset value 100).
- R11: The clock-side code output carries the frequency code of the level on the clock-side index. The voltage-side code output carries the voltage code of the level on the voltage-side index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Register and control clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| max_perf_req | input | 1 | Hardware demand for the highest level |
| work_active | input | 1 | High on cycles counted as work |
| clk_lvl_therm | input | 3 | Clock side's reported level, thermometer code, asynchronous |
| volt_lvl_therm | input | 3 | Voltage side's reported level, thermometer code, asynchronous |
| clk_tgt_idx | output | 2 | Target index sent to the clock side |
| clk_freq_code | output | 8 | Frequency code of the clock-side target |
| volt_tgt_idx | output | 2 | Target index sent to the voltage side |
| volt_code | output | 8 | Voltage code of the voltage-side target |

## Verification
A wrong sequencer state appears at the two index ports within one cycle of the side reports settling. The sign is one index moving ahead of its partner's confirmed level, or the two indices disagreeing while status shows not busy. A fault in the synchronizer appears in the status level fields about four cycles after the thermometer input changes. It shows as a level that tracks glitches or illegal patterns, or that moves too early. A mapping or clamp fault appears in the status target field as soon as the next transition has finished, and a work-meter fault appears in the work register one window later.

// File: rtl/perf_pkg.sv
// Shared definitions for the performance level scaling controller.
// Assumes requests are percentages encoded in seven bits.
package perf_pkg;
    localparam int          PCT_W    = 7;
    localparam logic [6:0]  PCT_FULL = 7'd100;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_VOLT_UP,
        SQ_CLK_UP,
        SQ_CLK_DN,
        SQ_VOLT_DN
    } seq_state_t;

    function automatic logic [PCT_W-1:0] clamp_pct(input logic [31:0] v);
        return (v > 32'(PCT_FULL)) ? PCT_FULL : v[PCT_W-1:0];
    endfunction
endpackage

// File: rtl/perf_thermo_sync.sv
// Brings an asynchronous thermometer-coded level into the local clock domain.
// Two flops synchronize; a third holds the previous sample. The confirmed
// level updates only when two consecutive samples agree and are legal.
// Assumes the remote side changes its code slowly compared to this clock.
module perf_thermo_sync #(
    parameter int W  = 3,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  therm_in,
    output logic [LW-1:0] lvl
);
    logic [W-1:0]  s1, s2, s3;
    logic          accept;
    logic [LW-1:0] ones;

    // Synchronizer chain plus previous-sample register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= therm_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Legality, stability and population count of the latest sample
    always_comb begin
        accept = ((s2 & (s2 + W'(1))) == '0) && (s2 == s3);
        ones   = '0;
        for (int i = 0; i < W; i++) ones = ones + LW'(s2[i]);
    end

    // Confirmed level register
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl <= '0;
        else if (accept) lvl <= ones;
    end
endmodule

// File: rtl/perf_seq.sv
// Transition sequencer: moves the two scaling sides to a wanted index.
// Raising leads with voltage; lowering leads with clock. A new wanted index
// is sampled only when idle, so the last request written while busy wins.
// Assumes each side eventually reports the index it was sent.
module perf_seq
    import perf_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] want_idx,
    input  logic [IW-1:0] clk_lvl,
    input  logic [IW-1:0] volt_lvl,
    output logic [IW-1:0] tgt_idx,
    output logic [IW-1:0] clk_idx,
    output logic [IW-1:0] volt_idx,
    output logic          busy
);
    seq_state_t st;

    // Ordered transition state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_IDLE;
            tgt_idx  <= '0;
            clk_idx  <= '0;
            volt_idx <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (want_idx > tgt_idx) begin
                        tgt_idx  <= want_idx;
                        volt_idx <= want_idx;
                        st       <= SQ_VOLT_UP;
                    end else if (want_idx < tgt_idx) begin
                        tgt_idx  <= want_idx;
                        clk_idx  <= want_idx;
                        st       <= SQ_CLK_DN;
                    end
                end
                SQ_VOLT_UP: begin
                    if (volt_lvl == tgt_idx) begin
                        clk_idx <= tgt_idx;
                        st      <= SQ_CLK_UP;
                    end
                end
                SQ_CLK_UP: begin
                    if (clk_lvl == tgt_idx) st <= SQ_IDLE;
                end
                SQ_CLK_DN: begin
                    if (clk_lvl == tgt_idx) begin
                        volt_idx <= tgt_idx;
                        st       <= SQ_VOLT_DN;
                    end
                end
                SQ_VOLT_DN: begin
                    if (volt_lvl == tgt_idx) st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (st != SQ_IDLE);
endmodule

// File: rtl/perf_work.sv
// Work meter: counts active cycles over a window of win_len cycles and
// publishes the count of the last full window. A window length of 0
// behaves as 1. Assumes win_len changes only occasionally.
module perf_work #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [CW-1:0] win_len,
    output logic [CW-1:0] result
);
    logic [CW-1:0] cnt, acc, last;

    assign last = (win_len == '0) ? '0 : win_len - CW'(1);

    // Window counter and accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            acc    <= '0;
            result <= '0;
        end else if (cnt >= last) begin
            result <= acc + CW'(active);
            acc    <= '0;
            cnt    <= '0;
        end else begin
            acc <= acc + CW'(active);
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/perf_regs.sv
// Register file and request mapping. Holds the request, the window length
// and the per-level table; maps the request to the wanted index; selects
// the code outputs. Zero-wait APB: writes take effect in the access phase,
// reads decode the address combinationally. Assumes IW <= 8.
module perf_regs
    import perf_pkg::*;
#(
    parameter int NLVL = 4,
    parameter int IW   = 2,
    parameter int CW   = 16,
    parameter int AW   = 8
) (
    input  logic             pclk,
    input  logic             presetn,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [31:0]      pwdata,
    output logic [31:0]      prdata,
    input  logic             max_req,
    input  logic [IW-1:0]    tgt_idx,
    input  logic [IW-1:0]    clk_lvl,
    input  logic [IW-1:0]    volt_lvl,
    input  logic             busy,
    input  logic [CW-1:0]    work_cnt,
    input  logic [IW-1:0]    clk_idx,
    input  logic [IW-1:0]    volt_idx,
    output logic [IW-1:0]    want_idx,
    output logic [7:0]       clk_code,
    output logic [7:0]       volt_code,
    output logic [CW-1:0]    win_len,
    output logic [PCT_W-1:0] req_pct
);
    localparam int WA    = AW - 2;
    localparam int LBASE = 4;

    logic [NLVL-1:0][PCT_W-1:0] thr;
    logic [NLVL-1:0][7:0]       fcode;
    logic [NLVL-1:0][7:0]       vcode;
    logic [WA-1:0]              word;
    logic                       wr_en;
    logic [IW-1:0]              map_idx;

    assign word  = paddr[AW-1:2];
    assign wr_en = psel & penable & pwrite;

    // Writable registers
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            req_pct <= '0;
            win_len <= CW'(100);
            for (int i = 0; i < NLVL; i++) begin
                thr[i]   <= PCT_W'(((i + 1) * 100) / NLVL);
                fcode[i] <= 8'(i);
                vcode[i] <= 8'(i);
            end
        end else if (wr_en) begin
            if (word == WA'(0)) req_pct <= clamp_pct(pwdata);
            if (word == WA'(2)) win_len <= pwdata[CW-1:0];
            for (int i = 0; i < NLVL; i++) begin
                if (word == WA'(LBASE + i)) begin
                    thr[i]   <= pwdata[PCT_W-1:0];
                    fcode[i] <= pwdata[15:8];
                    vcode[i] <= pwdata[23:16];
                end
            end
        end
    end

    // Lowest qualifying level, highest level by default or on hardware demand
    always_comb begin
        map_idx = IW'(NLVL - 1);
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (thr[i] >= req_pct) map_idx = IW'(i);
        end
        want_idx = max_req ? IW'(NLVL - 1) : map_idx;
    end

    // Code selection for each side
    assign clk_code  = fcode[clk_idx];
    assign volt_code = vcode[volt_idx];

    // Read decode
    always_comb begin
        prdata = '0;
        if (word == WA'(0)) prdata[PCT_W-1:0] = req_pct;
        if (word == WA'(1)) begin
            prdata[IW-1:0]    = tgt_idx;
            prdata[8 +: IW]   = clk_lvl;
            prdata[16 +: IW]  = volt_lvl;
            prdata[31]        = busy;
        end
        if (word == WA'(2)) prdata[CW-1:0] = win_len;
        if (word == WA'(3)) prdata[CW-1:0] = work_cnt;
        for (int i = 0; i < NLVL; i++) begin
            if (word == WA'(LBASE + i))
                prdata[23:0] = {vcode[i], fcode[i], 1'b0, thr[i]};
        end
    end
endmodule

// File: rtl/perf_scale_ctrl.sv
// Top of the performance level scaling controller. Connects the register
// file, the two level synchronizers, the transition sequencer and the work
// meter. Assumes the thermometer inputs are asynchronous to pclk.
module perf_scale_ctrl #(
    parameter int NLVL = 4,
    parameter int CW   = 16,
    parameter int AW   = 8
) (
    input  logic                      pclk,
    input  logic                      presetn,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [AW-1:0]             paddr,
    input  logic [31:0]               pwdata,
    output logic [31:0]               prdata,
    input  logic                      max_perf_req,
    input  logic                      work_active,
    input  logic [NLVL-2:0]           clk_lvl_therm,
    input  logic [NLVL-2:0]           volt_lvl_therm,
    output logic [$clog2(NLVL)-1:0]   clk_tgt_idx,
    output logic [7:0]                clk_freq_code,
    output logic [$clog2(NLVL)-1:0]   volt_tgt_idx,
    output logic [7:0]                volt_code
);
    localparam int IW  = $clog2(NLVL);
    localparam int THW = NLVL - 1;

    logic [IW-1:0] want_idx, tgt_idx, clk_conf, volt_conf;
    logic          seq_busy;
    logic [CW-1:0] win_len, work_cnt;
    logic [6:0]    req_pct;

    perf_regs #(.NLVL(NLVL), .IW(IW), .CW(CW), .AW(AW)) u_regs (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .max_req(max_perf_req), .tgt_idx(tgt_idx), .clk_lvl(clk_conf),
        .volt_lvl(volt_conf), .busy(seq_busy), .work_cnt(work_cnt),
        .clk_idx(clk_tgt_idx), .volt_idx(volt_tgt_idx), .want_idx(want_idx),
        .clk_code(clk_freq_code), .volt_code(volt_code), .win_len(win_len),
        .req_pct(req_pct)
    );

    perf_thermo_sync #(.W(THW), .LW(IW)) u_sync_clk (
        .clk(pclk), .rst_n(presetn), .therm_in(clk_lvl_therm), .lvl(clk_conf)
    );

    perf_thermo_sync #(.W(THW), .LW(IW)) u_sync_volt (
        .clk(pclk), .rst_n(presetn), .therm_in(volt_lvl_therm), .lvl(volt_conf)
    );

    perf_seq #(.IW(IW)) u_seq (
        .clk(pclk), .rst_n(presetn), .want_idx(want_idx), .clk_lvl(clk_conf),
        .volt_lvl(volt_conf), .tgt_idx(tgt_idx), .clk_idx(clk_tgt_idx),
        .volt_idx(volt_tgt_idx), .busy(seq_busy)
    );

    perf_work #(.CW(CW)) u_work (
        .clk(pclk), .rst_n(presetn), .active(work_active), .win_len(win_len),
        .result(work_cnt)
    );
endmodule

// File: rtl/perf_scale_chk.sv
// Property checker for the performance level scaling controller, bound
// into every instance of the top. Observes indices, confirmed levels and
// the stored request.
module perf_scale_chk #(
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] clk_idx,
    input logic [IW-1:0] volt_idx,
    input logic [IW-1:0] clk_lvl,
    input logic [IW-1:0] volt_lvl,
    input logic          busy,
    input logic [6:0]    req_pct
);
    p_volt_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_idx > $past(clk_idx)) |-> ($past(volt_lvl) == clk_idx));

    p_clk_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_idx < $past(volt_idx)) |-> ($past(clk_lvl) == volt_idx));

    p_idle_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (clk_idx == volt_idx));

    p_req_clamped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_pct <= 7'd100);
endmodule

bind perf_scale_ctrl perf_scale_chk #(.IW(IW)) u_chk (
    .clk(pclk), .rst_n(presetn), .clk_idx(clk_tgt_idx), .volt_idx(volt_tgt_idx),
    .clk_lvl(clk_conf), .volt_lvl(volt_conf), .busy(seq_busy), .req_pct(req_pct)
);

// File: tb/perf_scale_ctrl_tb.sv
// Directed bench for the performance level scaling controller.
module perf_scale_ctrl_tb;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        max_perf_req = 1'b0;
    logic        work_active = 1'b0;
    logic [2:0]  clk_lvl_therm, volt_lvl_therm;
    logic [1:0]  clk_tgt_idx, volt_tgt_idx;
    logic [7:0]  clk_freq_code, volt_code;

    logic        hold_c = 1'b0, hold_v = 1'b0, force_c = 1'b0;
    logic [2:0]  force_cval = '0, c_agent = '0, v_agent = '0;
    int          c_cnt = 0, v_cnt = 0;
    int          vectors = 0, miscompares = 0;
    logic [31:0] rd;

    always #10 pclk = ~pclk;

    perf_scale_ctrl u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .max_perf_req(max_perf_req), .work_active(work_active),
        .clk_lvl_therm(clk_lvl_therm), .volt_lvl_therm(volt_lvl_therm),
        .clk_tgt_idx(clk_tgt_idx), .clk_freq_code(clk_freq_code),
        .volt_tgt_idx(volt_tgt_idx), .volt_code(volt_code)
    );

    function automatic logic [2:0] th(input logic [1:0] i);
        return 3'((4'd1 << i) - 4'd1);
    endfunction

    assign clk_lvl_therm  = force_c ? force_cval : c_agent;
    assign volt_lvl_therm = v_agent;

    // Clock-side agent model: follows its index after a short delay
    always @(posedge pclk) begin
        if (!hold_c && c_agent != th(clk_tgt_idx)) begin
            if (c_cnt == 2) begin c_agent <= th(clk_tgt_idx); c_cnt <= 0; end
            else c_cnt <= c_cnt + 1;
        end else c_cnt <= 0;
    end

    // Voltage-side agent model: slower follower
    always @(posedge pclk) begin
        if (!hold_v && v_agent != th(volt_tgt_idx)) begin
            if (v_cnt == 5) begin v_agent <= th(volt_tgt_idx); v_cnt <= 0; end
            else v_cnt <= v_cnt + 1;
        end else v_cnt <= 0;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        #1 d = prdata;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_idle();
        int seen = 0;
        repeat (2) @(negedge pclk);
        for (int n = 0; n < 2000 && seen < 2; n++) begin
            apb_read(8'h04, rd);
            if (!rd[31]) seen++; else seen = 0;
        end
    endtask

    task automatic go(input int pct, input logic [1:0] exp, input string tag);
        apb_write(8'h00, 32'(pct));
        wait_idle();
        apb_read(8'h04, rd);
        chk({tag, " status target"}, {30'd0, rd[1:0]}, {30'd0, exp});
        chk({tag, " clk idx"}, {30'd0, clk_tgt_idx}, {30'd0, exp});
        chk({tag, " volt idx"}, {30'd0, volt_tgt_idx}, {30'd0, exp});
    endtask

    task automatic t_reset();
        apb_read(8'h04, rd);
        chk("R1 R7 status after reset", rd, 32'h0);
        apb_read(8'h00, rd);
        chk("R1 request after reset", rd, 32'h0);
        chk("R1 clk idx", {30'd0, clk_tgt_idx}, 32'd0);
        chk("R1 volt idx", {30'd0, volt_tgt_idx}, 32'd0);
        chk("R1 codes", {16'd0, clk_freq_code, volt_code}, 32'd0);
        apb_read(8'h18, rd);
        chk("R1 level2 reset entry", rd, 32'h0002_024B);
    endtask

    task automatic t_clamp();
        apb_write(8'h00, 32'd150);
        apb_read(8'h00, rd);
        chk("R2 clamp readback", rd, 32'd100);
        wait_idle();
        apb_read(8'h04, rd);
        chk("R2 R3 clamped target", {30'd0, rd[1:0]}, 32'd3);
        chk("R7 status levels", {16'd0, rd[23:16], rd[15:8]}, 32'h0000_0303);
    endtask

    task automatic t_map();
        go(30, 2'd1, "R3 map 30");
        go(50, 2'd1, "R3 map 50 equal");
        go(0, 2'd0, "R3 map 0");
        go(51, 2'd2, "R3 map 51");
        apb_write(8'h14, 32'h0001_013C);
        go(55, 2'd1, "R3 map 55 with level1 at 60");
        apb_write(8'h1C, 32'h0003_035A);
        go(95, 2'd3, "R3 map 95 none qualifies");
        apb_write(8'h14, 32'h0001_0132);
        apb_write(8'h1C, 32'h0003_0364);
        go(0, 2'd0, "R3 map back to 0");
    endtask

    task automatic t_raise();
        hold_v = 1'b1;
        apb_write(8'h00, 32'd80);
        repeat (20) @(negedge pclk);
        chk("R4 volt leads", {30'd0, volt_tgt_idx}, 32'd3);
        chk("R4 clk waits", {30'd0, clk_tgt_idx}, 32'd0);
        apb_read(8'h04, rd);
        chk("R7 R4 busy during rise", {31'd0, rd[31]}, 32'd1);
        hold_v = 1'b0;
        wait_idle();
        chk("R4 clk raised", {30'd0, clk_tgt_idx}, 32'd3);
    endtask

    task automatic t_lower();
        hold_c = 1'b1;
        apb_write(8'h00, 32'd10);
        repeat (20) @(negedge pclk);
        chk("R5 clk leads", {30'd0, clk_tgt_idx}, 32'd0);
        chk("R5 volt waits", {30'd0, volt_tgt_idx}, 32'd3);
        hold_c = 1'b0;
        wait_idle();
        chk("R5 volt lowered", {30'd0, volt_tgt_idx}, 32'd0);
    endtask

    task automatic t_pending();
        hold_v = 1'b1;
        apb_write(8'h00, 32'd80);
        repeat (5) @(negedge pclk);
        apb_write(8'h00, 32'd30);
        apb_write(8'h00, 32'd60);
        repeat (5) @(negedge pclk);
        chk("R8 transition undisturbed volt", {30'd0, volt_tgt_idx}, 32'd3);
        chk("R8 transition undisturbed clk", {30'd0, clk_tgt_idx}, 32'd0);
        hold_v = 1'b0;
        wait_idle();
        apb_read(8'h04, rd);
        chk("R8 last pending applied", {30'd0, rd[1:0]}, 32'd2);
        chk("R8 idle indices agree", {30'd0, clk_tgt_idx}, {30'd0, volt_tgt_idx});
        go(0, 2'd0, "R8 return to 0");
    endtask

    task automatic t_max();
        @(negedge pclk);
        max_perf_req = 1'b1;
        wait_idle();
        apb_read(8'h04, rd);
        chk("R9 forced to top", {30'd0, rd[1:0]}, 32'd3);
        apb_write(8'h00, 32'd20);
        wait_idle();
        apb_read(8'h04, rd);
        chk("R9 software ignored while forced", {30'd0, rd[1:0]}, 32'd3);
        @(negedge pclk);
        max_perf_req = 1'b0;
        wait_idle();
        apb_read(8'h04, rd);
        chk("R9 released to mapping", {30'd0, rd[1:0]}, 32'd0);
    endtask

    task automatic t_sync();
        hold_c = 1'b1;
        @(negedge pclk);
        force_c = 1'b1; force_cval = 3'b101;
        repeat (10) @(negedge pclk);
        apb_read(8'h04, rd);
        chk("R6 illegal pattern ignored", {24'd0, rd[15:8]}, 32'd0);
        @(negedge pclk);
        force_cval = 3'b011;
        repeat (2) @(negedge pclk);
        apb_read(8'h04, rd);
        chk("R6 not yet confirmed at third edge", {24'd0, rd[15:8]}, 32'd0);
        apb_read(8'h04, rd);
        chk("R6 confirmed after stable samples", {24'd0, rd[15:8]}, 32'd2);
        @(negedge pclk);
        force_cval = 3'b001;
        @(negedge pclk);
        force_cval = 3'b011;
        repeat (8) @(negedge pclk);
        apb_read(8'h04, rd);
        chk("R6 glitch ignored", {24'd0, rd[15:8]}, 32'd2);
        force_c = 1'b0;
        hold_c = 1'b0;
        repeat (8) @(negedge pclk);
        apb_read(8'h04, rd);
        chk("R6 back to agent level", {24'd0, rd[15:8]}, 32'd0);
    endtask

    task automatic t_work();
        apb_write(8'h08, 32'd10);
        @(negedge pclk);
        work_active = 1'b1;
        repeat (30) @(negedge pclk);
        apb_read(8'h0C, rd);
        chk("R10 all active", rd, 32'd10);
        work_active = 1'b0;
        repeat (30) @(negedge pclk);
        apb_read(8'h0C, rd);
        chk("R10 none active", rd, 32'd0);
        for (int k = 0; k < 40; k++) begin
            @(negedge pclk);
            work_active = ~work_active;
        end
        apb_read(8'h0C, rd);
        chk("R10 half active", rd, 32'd5);
    endtask

    task automatic t_codes();
        apb_write(8'h14, 32'h00C3_5A32);
        go(40, 2'd1, "R11 move to level1");
        chk("R11 freq code", {24'd0, clk_freq_code}, 32'h5A);
        chk("R11 volt code", {24'd0, volt_code}, 32'hC3);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge pclk);
        miscompares++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Test sequence
    initial begin
        repeat (4) @(negedge pclk);
        presetn = 1'b1;
        repeat (2) @(negedge pclk);
        t_reset();
        t_clamp();
        t_map();
        t_raise();
        t_lower();
        t_pending();
        t_max();
        t_sync();
        t_work();
        t_codes();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule